// File: doc/BRIEF.md
# Vertical Blanking Line Generator

This block produces the vertical blanking level for interlaced 525-line and 625-line video timing. It keeps a line counter that a frame-start pulse clears and a per-line strobe advances. From two programmable line numbers, given once for the odd field, it decides on every line whether the picture is blanked or active. The window for the second (even) field is placed by adding a fixed offset that depends on the line standard: 262 lines for 525-line timing and 313 lines for 625-line timing.

The programmable settings are the 9-bit blanking start line (an 8-bit low part and a 1-bit high part), the 8-bit active start line, the line standard and the blanking-output enable. All of them are copied into a shadow set only when an odd field starts. A change made in the middle of a field therefore cannot move an edge inside that field. A noninterlaced-input mode flag exists for the capture side. It does not change the output timing, which still follows the interlaced odd/even placement.

Top module: `vbl_blank_gen`

## Requirements
- R1: After reset, `line_cnt` is 0, `blank_o` is 0 and `active_o` is 1, and the shadow settings hold the standard 525-line timing with output disabled.
- R2: A pulse on `odd_start` makes `line_cnt` read 0 in the following cycle and loads the shadow settings from the inputs. It takes priority over a `line_stb` in the same cycle.
- R3: Each `line_stb` without `odd_start` advances `line_cnt` by one. The counter wraps from 524 to 0 when `std_pal`=0 and from 624 to 0 when `std_pal`=1. With no strobe, the count holds.
- R4: With output enabled, in the first field `blank_o` is 0 exactly when E ≤ `line_cnt` < S. Here E is `act_line` and S is {`blk_start_hi`,`blk_start_lo`}. On all other first-field lines `blank_o` is 1.
- R5: With output enabled and `std_pal`=0, `blank_o` is also 0 when E+262 ≤ `line_cnt` < S+262.
- R6: With output enabled and `std_pal`=1, the second active window is E+313 ≤ `line_cnt` < S+313.
- R7: `active_o` is always the inverse of `blank_o`.
- R8: With the shadowed enable at 0, `blank_o` stays 0 and `active_o` stays 1, whatever the start and end lines are.
- R9: Changes to `blk_start_hi`, `blk_start_lo`, `act_line`, `std_pal` or `blank_oe` have no effect on outputs until the next `odd_start`.
- R10: `sif_mode`=1 leaves `blank_o`, `active_o` and `line_cnt` identical to `sif_mode`=0 for the same stimulus.
- R11: `blk_start_hi` is bit 8 of the blanking start line, so a start line of 259 is `blk_start_hi`=1 with `blk_start_lo`=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-cycle pulse per line |
| odd_start | input | 1 | One-cycle pulse at the VSYNC edge that opens an odd field |
| std_pal | input | 1 | 0: 525-line timing, 1: 625-line timing |
| sif_mode | input | 1 | Noninterlaced input mode flag |
| blank_oe | input | 1 | Blanking output enable |
| blk_start_lo | input | 8 | Blanking start line, bits 7..0 |
| blk_start_hi | input | 1 | Blanking start line, bit 8 |
| act_line | input | 8 | First active line of the odd field |
| blank_o | output | 1 | Vertical blanking level |
| active_o | output | 1 | Active video flag |
| line_cnt | output | 10 | Current line within the frame |

## Verification
The bench builds the block with its default parameters: a 10-bit counter, frame lengths of 525 and 625 lines, and field offsets of 262 and 313. Full frames of both standards can therefore be stepped line by line in a few thousand cycles. This reaches both wrap points and both even-field windows. It also reaches a blanking start line above 255 that exercises the high start bit. Mid-field setting changes and the simultaneous frame-start-and-strobe case are driven as well.

// File: rtl/vbl_pkg.sv
package vbl_pkg;

  typedef enum logic {
    STD_525 = 1'b0,
    STD_625 = 1'b1
  } vstd_e;

  localparam int FIELDS = 2;

endpackage

// File: rtl/vbl_rst_sync.sv
module vbl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/vbl_cfg_shadow.sv
module vbl_cfg_shadow
  import vbl_pkg::*;
#(
  parameter int START_W = 9,
  parameter int END_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [START_W-1:0] start_i,
  input  logic [END_W-1:0]   end_i,
  input  vstd_e              std_i,
  input  logic               oe_i,
  output logic [START_W-1:0] start_q,
  output logic [END_W-1:0]   end_q,
  output vstd_e              std_q,
  output logic               oe_q
);

  logic [START_W-1:0] start_d;
  logic [END_W-1:0]   end_d;
  vstd_e              std_d;
  logic               oe_d;

  always_comb begin
    start_d = start_q;
    end_d   = end_q;
    std_d   = std_q;
    oe_d    = oe_q;
    if (load) begin
      start_d = start_i;
      end_d   = end_i;
      std_d   = std_i;
      oe_d    = oe_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      std_q   <= STD_525;
      oe_q    <= 1'b0;
    end else begin
      start_q <= start_d;
      end_q   <= end_d;
      std_q   <= std_d;
      oe_q    <= oe_d;
    end
  end

endmodule

// File: rtl/vbl_line_counter.sv
module vbl_line_counter
  import vbl_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int LINES_525  = 525,
  parameter int LINES_625  = 625
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  vstd_e            std,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] LAST_525 = CNT_W'(LINES_525 - 1);
  localparam logic [CNT_W-1:0] LAST_625 = CNT_W'(LINES_625 - 1);

  logic [CNT_W-1:0] last_line;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign last_line = (std == STD_625) ? LAST_625 : LAST_525;
  assign cnt_en    = clr | adv;

  always_comb begin
    cnt_d = cnt;
    if (clr) begin
      cnt_d = '0;
    end else if (adv) begin
      cnt_d = (cnt == last_line) ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/vbl_window_decode.sv
module vbl_window_decode
  import vbl_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int START_W = 9,
  parameter int END_W   = 8,
  parameter int OFS_525 = 262,
  parameter int OFS_625 = 313
) (
  input  logic [CNT_W-1:0]   cnt,
  input  logic [START_W-1:0] start_line,
  input  logic [END_W-1:0]   act_line,
  input  vstd_e              std,
  input  logic               oe,
  output logic               blank,
  output logic               active
);

  localparam int SUM_W = ((CNT_W > START_W) ? CNT_W : START_W) + 1;

  logic [SUM_W-1:0]  cnt_ext;
  logic [SUM_W-1:0]  even_ofs;
  logic [FIELDS-1:0] in_win;
  logic              any_win;

  assign cnt_ext  = SUM_W'(cnt);
  assign even_ofs = (std == STD_625) ? SUM_W'(OFS_625) : SUM_W'(OFS_525);

  for (genvar f = 0; f < FIELDS; f++) begin : g_field
    logic [SUM_W-1:0] ofs;
    logic [SUM_W-1:0] win_lo;
    logic [SUM_W-1:0] win_hi;
    assign ofs       = (f == 0) ? '0 : even_ofs;
    assign win_lo    = SUM_W'(act_line) + ofs;
    assign win_hi    = SUM_W'(start_line) + ofs;
    assign in_win[f] = (cnt_ext >= win_lo) && (cnt_ext < win_hi);
  end

  assign any_win = |in_win;
  assign blank   = oe & ~any_win;
  assign active  = ~blank;

endmodule

// File: rtl/vbl_blank_gen.sv
module vbl_blank_gen
  import vbl_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int START_LO_W = 8,
  parameter int START_W    = 9,
  parameter int END_W      = 8,
  parameter int LINES_525  = 525,
  parameter int LINES_625  = 625,
  parameter int OFS_525    = 262,
  parameter int OFS_625    = 313
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          line_stb,
  input  logic                          odd_start,
  input  logic                          std_pal,
  input  logic                          sif_mode,
  input  logic                          blank_oe,
  input  logic [START_LO_W-1:0]         blk_start_lo,
  input  logic [START_W-START_LO_W-1:0] blk_start_hi,
  input  logic [END_W-1:0]              act_line,
  output logic                          blank_o,
  output logic                          active_o,
  output logic [CNT_W-1:0]              line_cnt
);

  logic               rst_n_int;
  logic [START_W-1:0] start_in;
  vstd_e              std_in;
  logic [START_W-1:0] start_sh;
  logic [END_W-1:0]   end_sh;
  vstd_e              std_sh;
  logic               oe_sh;
  logic               unused_sif_mode;

  assign unused_sif_mode = sif_mode;
  assign start_in        = {blk_start_hi, blk_start_lo};
  assign std_in          = std_pal ? STD_625 : STD_525;

  vbl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  vbl_cfg_shadow #(
    .START_W (START_W),
    .END_W   (END_W)
  ) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .load    (odd_start),
    .start_i (start_in),
    .end_i   (act_line),
    .std_i   (std_in),
    .oe_i    (blank_oe),
    .start_q (start_sh),
    .end_q   (end_sh),
    .std_q   (std_sh),
    .oe_q    (oe_sh)
  );

  vbl_line_counter #(
    .CNT_W     (CNT_W),
    .LINES_525 (LINES_525),
    .LINES_625 (LINES_625)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n_int),
    .clr   (odd_start),
    .adv   (line_stb),
    .std   (std_sh),
    .cnt   (line_cnt)
  );

  vbl_window_decode #(
    .CNT_W   (CNT_W),
    .START_W (START_W),
    .END_W   (END_W),
    .OFS_525 (OFS_525),
    .OFS_625 (OFS_625)
  ) u_win (
    .cnt        (line_cnt),
    .start_line (start_sh),
    .act_line   (end_sh),
    .std        (std_sh),
    .oe         (oe_sh),
    .blank      (blank_o),
    .active     (active_o)
  );

endmodule

// File: rtl/vbl_blank_gen_chk.sv
module vbl_blank_gen_chk #(
  parameter int CNT_W     = 10,
  parameter int LINES_625 = 625
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_stb,
  input logic             odd_start,
  input logic             blank_o,
  input logic             active_o,
  input logic [CNT_W-1:0] line_cnt
);

  // R2: frame start clears the count
  p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    odd_start |=> (line_cnt == '0));

  // R3: a strobe advances by one or wraps to zero
  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && !odd_start) |=> ((line_cnt == $past(line_cnt) + 1'b1) || (line_cnt == '0)));

  // R3: no strobe, no movement
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_stb && !odd_start) |=> $stable(line_cnt));

  // R3: count stays inside the longest frame
  p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    line_cnt < CNT_W'(LINES_625));

  // R7: the two outputs are complementary
  p_active_inverse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    active_o != blank_o);

  // R9: without a line step or a frame start the blanking level cannot move
  p_no_midline_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_stb && !odd_start) |=> $stable(blank_o));

endmodule

bind vbl_blank_gen vbl_blank_gen_chk #(
  .CNT_W     (CNT_W),
  .LINES_625 (LINES_625)
) u_vbl_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_stb  (line_stb),
  .odd_start (odd_start),
  .blank_o   (blank_o),
  .active_o  (active_o),
  .line_cnt  (line_cnt)
);

// File: tb/tb_vbl_blank_gen.sv
module tb_vbl_blank_gen;

  logic       clk;
  logic       rst_n;
  logic       line_stb;
  logic       odd_start;
  logic       std_pal;
  logic       sif_mode;
  logic       blank_oe;
  logic [7:0] blk_start_lo;
  logic [0:0] blk_start_hi;
  logic [7:0] act_line;
  logic       blank_o;
  logic       active_o;
  logic [9:0] line_cnt;

  vbl_blank_gen dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_stb     (line_stb),
    .odd_start    (odd_start),
    .std_pal      (std_pal),
    .sif_mode     (sif_mode),
    .blank_oe     (blank_oe),
    .blk_start_lo (blk_start_lo),
    .blk_start_hi (blk_start_hi),
    .act_line     (act_line),
    .blank_o      (blank_o),
    .active_o     (active_o),
    .line_cnt     (line_cnt)
  );

  typedef struct {
    int    due;
    int    cnt;
    bit    blank;
    bit    active;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 0;

  // model state, derived from the requirements
  int m_cnt = 0;
  int m_start = 0;
  int m_end = 0;
  bit m_pal = 0;
  bit m_oe = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit exp_blank(int c);
    int ofs;
    bit act;
    if (!m_oe) return 1'b0;
    ofs = m_pal ? 313 : 262;
    act = ((c >= m_end) && (c < m_start)) ||
          ((c >= m_end + ofs) && (c < m_start + ofs));
    return !act;
  endfunction

  task automatic compare(exp_t e);
    n_checks++;
    if (line_cnt !== 10'(e.cnt) || blank_o !== e.blank || active_o !== e.active) begin
      n_fail++;
      $display("FAIL %s: cnt=%0d blank=%0b active=%0b expected cnt=%0d blank=%0b active=%0b",
               e.tag, line_cnt, blank_o, active_o, e.cnt, e.blank, e.active);
    end
  endtask

  // monitor: pops expected items once the design has produced them
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      compare(q.pop_front());
    end
  end

  // driver: one cycle of stimulus, expectation pushed to the scoreboard
  task automatic step(input bit stb, input bit ods, input string tag);
    exp_t e;
    int   last;
    @(negedge clk);
    line_stb  = stb;
    odd_start = ods;
    if (ods) begin
      m_cnt   = 0;
      m_start = {blk_start_hi, blk_start_lo};
      m_end   = act_line;
      m_pal   = std_pal;
      m_oe    = blank_oe;
    end else if (stb) begin
      last  = m_pal ? 624 : 524;
      m_cnt = (m_cnt == last) ? 0 : m_cnt + 1;
    end
    e.due    = cyc + 1;
    e.cnt    = m_cnt;
    e.blank  = exp_blank(m_cnt);
    e.active = !e.blank;
    e.tag    = tag;
    q.push_back(e);
  endtask

  function automatic string line_tag(bit pal_run);
    if (m_cnt == 0) return "R3";
    if (!pal_run && m_cnt == 259) return "R11";
    if (m_cnt < (pal_run ? 313 : 262)) return "R4";
    return pal_run ? "R6" : "R5";
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    #1000000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin : stimulus
    rst_n        = 1'b0;
    line_stb     = 1'b0;
    odd_start    = 1'b0;
    std_pal      = 1'b0;
    sif_mode     = 1'b0;
    blank_oe     = 1'b1;
    blk_start_hi = 1'b1;
    blk_start_lo = 8'd3;
    act_line     = 8'd22;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    n_checks++;
    if (line_cnt !== 10'd0 || blank_o !== 1'b0 || active_o !== 1'b1) begin
      n_fail++;
      $display("FAIL R1: cnt=%0d blank=%0b active=%0b expected cnt=0 blank=0 active=1",
               line_cnt, blank_o, active_o);
    end

    // R2 then a full 525-line frame, start line 259 (R11), active from 22
    step(0, 1, "R2");
    for (int i = 0; i < 525; i++) begin
      step(1, 0, "R4");
      q[$].tag = line_tag(0);
      if (i % 97 == 0) step(0, 0, "R3");
    end

    // R9: settings change mid-field, no frame start
    act_line     = 8'd40;
    blk_start_lo = 8'd44;
    std_pal      = 1'b1;
    for (int i = 0; i < 60; i++) step(1, 0, "R9");

    // R6: 625-line frame with start 300, active from 40
    step(0, 1, "R2");
    for (int i = 0; i < 625; i++) begin
      step(1, 0, "R6");
      q[$].tag = line_tag(1);
    end

    // R2: frame start wins over a simultaneous strobe
    for (int i = 0; i < 10; i++) step(1, 0, "R3");
    step(1, 1, "R2");
    for (int i = 0; i < 50; i++) step(1, 0, "R7");

    // R8: output disabled, settings must not matter
    blank_oe = 1'b0;
    step(0, 1, "R8");
    for (int i = 0; i < 80; i++) step(1, 0, "R8");

    // R10: noninterlaced mode, same 525-line expectations
    blank_oe     = 1'b1;
    std_pal      = 1'b0;
    blk_start_lo = 8'd3;
    act_line     = 8'd22;
    sif_mode     = 1'b1;
    step(0, 1, "R10");
    for (int i = 0; i < 525; i++) step(1, 0, "R10");

    step(0, 0, "R3");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule